// File: doc/BRIEF.md
# Averaging SAR Conversion Sequencer

This block runs the digital side of a 10-bit successive-approximation converter. A one-cycle start request, taken while the block is idle, launches a conversion cycle. The cycle is one conversion, or a programmed power-of-two number of conversions whose results are summed and then divided by shifting. The block drives a trial code to an external DAC and reads back one comparator bit. It reports the averaged result together with a busy level and a one-cycle done pulse.

All sequencing runs on a conversion-clock enable. This enable is a pulse in the system clock domain, produced once every 1, 2, 4 … 128 system cycles. Each conversion takes twelve enable edges: a sample edge, ten bit-decision edges and a load edge. The divider selection and the averaging selection are captured when a start is accepted. After that, the input pins may change freely.

Top module: `aux_sar_seq`

## Requirements
- R1: After reset, busy_o, done_o, result_o and dac_code_o are all zero.
- R2: A start_i seen at a clock edge while busy_o is low sets busy_o from that edge on.
- R3: Bits are decided MSB first. At each decision edge the trial bit is kept when cmp_i is 1 and cleared when it is 0, and the next lower bit is set as the new trial. With cmp_i = (dac_code_o <= level), one conversion returns the level.
- R4: A divider selection d (3 bits) sets the conversion-clock period to 2^d system cycles, for d = 0 to 7.
- R5: An averaging selection a (3 bits) gives 2^a conversions for a = 0 to 5; codes 6 and 7 both give 32. The result is the floor of the sum divided by the count.
- R6: busy_o stays high for exactly 12 × count × divisor system cycles after the accepting edge. When busy_o falls, done_o is high for that one cycle and result_o holds the new value.
- R7: sample_o pulses once per conversion: the count of pulses in a cycle equals the averaging count, and the edge after a pulse puts 512 on dac_code_o.
- R8: A start_i seen while busy_o is high is ignored. The cycle in progress keeps its length and its result.
- R9: Changes of div_sel_i and avg_sel_i while busy_o is high do not change the running cycle.
- R10: result_o keeps its value between done pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request |
| div_sel_i | input | 3 | Conversion-clock divider selection (2^d) |
| avg_sel_i | input | 3 | Averaging count selection |
| cmp_i | input | 1 | Comparator bit, 1 = input at or above trial code |
| dac_code_o | output | 10 | Trial code for the DAC |
| sample_o | output | 1 | High on the cycle whose edge samples the input |
| result_o | output | 10 | Averaged conversion result |
| busy_o | output | 1 | Conversion cycle in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The accepting edge is the first rising edge that sees start_i. busy_o is due right after it. The done pulse, the fall of busy_o and the new result_o are all due exactly 12 × count × divisor edges later, and the bench counts those edges one by one. It checks busy_o on the cycle before that edge and the finished state on the cycle after it. All sampling happens at the falling edge, so each check reads the register state left by a known rising edge. A second start and altered selections are driven partway through some cycles, and the timing and results of those cycles are still checked against the original settings.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int RES_W_DEF   = 10;
  localparam int SEL_W_DEF   = 3;
  localparam int AVG_LOG_MAX = 5;

  // saturate an averaging selection to the largest supported log2 count
  function automatic int avg_log_of(input int sel, input int max_log);
    return (sel > max_log) ? max_log : sel;
  endfunction
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
  parameter int SEL_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             tick_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q, lim;

  assign lim    = {CNT_W{1'b1}} >> (SEL_W'(CNT_W) - div_sel_i);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] code_o,
  output logic             sample_o,
  output logic             load_o
);
  localparam int STEPS  = RES_W + 2;
  localparam int STEP_W = $clog2(STEPS);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(STEPS - 1);

  logic [STEP_W-1:0] step_q;
  logic [RES_W-1:0]  code_q, code_d;
  int                dec_idx;

  assign sample_o = tick_i && (step_q == '0);
  assign load_o   = tick_i && (step_q == LAST);
  assign code_o   = code_q;
  assign dec_idx  = RES_W - int'(step_q);

  always_comb begin
    code_d = code_q;
    if (sample_o) begin
      code_d = '0;
      code_d[RES_W-1] = 1'b1;
    end else if (tick_i && !load_o) begin
      for (int i = 0; i < RES_W; i++) begin
        if (i == dec_idx)     code_d[i] = cmp_i;
        if (i + 1 == dec_idx) code_d[i] = 1'b1;  // next trial bit
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      code_q <= '0;
    end else begin
      code_q <= code_d;
      if (!run_i)      step_q <= '0;
      else if (tick_i) step_q <= (step_q == LAST) ? '0 : step_q + 1'b1;
    end
  end
endmodule

// File: rtl/sar_accum.sv
module sar_accum #(
  parameter int RES_W   = 10,
  parameter int MAX_LOG = 5,
  parameter int AL_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [RES_W-1:0] code_i,
  input  logic [AL_W-1:0]  avg_log_i,
  output logic             last_o,
  output logic [RES_W-1:0] result_o
);
  localparam int ACC_W = RES_W + MAX_LOG;

  logic [MAX_LOG-1:0] conv_q, conv_lim;
  logic [ACC_W-1:0]   acc_q, sum;
  logic [RES_W-1:0]   res_q;

  assign conv_lim = {MAX_LOG{1'b1}} >> (AL_W'(MAX_LOG) - avg_log_i);
  assign last_o   = load_i && (conv_q == conv_lim);
  assign sum      = acc_q + ACC_W'(code_i);
  assign result_o = res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_q <= '0;
      acc_q  <= '0;
      res_q  <= '0;
    end else if (last_o) begin
      res_q  <= RES_W'(sum >> avg_log_i);
      acc_q  <= '0;
      conv_q <= '0;
    end else if (load_i) begin
      acc_q  <= sum;
      conv_q <= conv_q + 1'b1;
    end
  end
endmodule

// File: rtl/aux_sar_seq.sv
module aux_sar_seq #(
  parameter int RES_W   = sar_pkg::RES_W_DEF,
  parameter int SEL_W   = sar_pkg::SEL_W_DEF,
  parameter int MAX_LOG = sar_pkg::AVG_LOG_MAX
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SEL_W-1:0] div_sel_i,
  input  logic [SEL_W-1:0] avg_sel_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] dac_code_o,
  output logic             sample_o,
  output logic [RES_W-1:0] result_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int AL_W = $clog2(MAX_LOG + 1);

  logic             busy_q, done_q, start_ok, tick, load, last;
  logic [SEL_W-1:0] div_q;
  logic [AL_W-1:0]  avg_log_q, avg_log_d;

  assign start_ok  = start_i && !busy_q;
  assign avg_log_d = AL_W'(sar_pkg::avg_log_of(int'(avg_sel_i), MAX_LOG));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      div_q     <= '0;
      avg_log_q <= '0;
    end else begin
      done_q <= last;
      if (start_ok) begin
        busy_q    <= 1'b1;
        div_q     <= div_sel_i;
        avg_log_q <= avg_log_d;
      end else if (last) begin
        busy_q <= 1'b0;
      end
    end
  end

  sar_tick_gen #(.SEL_W(SEL_W)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy_q),
    .div_sel_i(div_q), .tick_o(tick)
  );

  sar_core #(.RES_W(RES_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy_q), .tick_i(tick),
    .cmp_i(cmp_i), .code_o(dac_code_o), .sample_o(sample_o), .load_o(load)
  );

  sar_accum #(.RES_W(RES_W), .MAX_LOG(MAX_LOG), .AL_W(AL_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .code_i(dac_code_o),
    .avg_log_i(avg_log_q), .last_o(last), .result_o(result_o)
  );

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_W = 10,
  parameter int SEL_W = 3,
  parameter int AL_W  = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             sample_o,
  input logic [RES_W-1:0] dac_code_o,
  input logic [RES_W-1:0] result_o,
  input logic [SEL_W-1:0] div_q,
  input logic [AL_W-1:0]  avg_log_q
);
  logic [31:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cyc_q <= '0;
    else if (busy_o) cyc_q <= cyc_q + 1;
    else             cyc_q <= '0;
  end

  a_r6_duration: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cyc_q == ((RES_W + 2) << (int'(div_q) + int'(avg_log_q)))));

  a_r6_done_at_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  a_r2_start_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);

  a_r8_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && busy_o) |=> ($stable(div_q) && $stable(avg_log_q)));

  a_r10_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(result_o));

  a_r7_sample_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> (dac_code_o == (RES_W'(1) << (RES_W - 1))));
endmodule

bind aux_sar_seq sar_seq_chk #(.RES_W(RES_W), .SEL_W(SEL_W), .AL_W(AL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .sample_o(sample_o), .dac_code_o(dac_code_o),
  .result_o(result_o), .div_q(div_q), .avg_log_q(avg_log_q)
);

// File: tb/sim_aux_sar_seq.sv
module sim_aux_sar_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // {div_sel, avg_sel, base level, step per conversion, inject mid-run start}
  localparam logic [20:0] VEC [NVEC] = '{
    {3'd0, 3'd0, 10'd0,    4'd0, 1'b0},
    {3'd0, 3'd0, 10'd1023, 4'd0, 1'b0},
    {3'd1, 3'd0, 10'd341,  4'd0, 1'b0},
    {3'd2, 3'd1, 10'd600,  4'd3, 1'b1},
    {3'd0, 3'd2, 10'd100,  4'd1, 1'b0},
    {3'd3, 3'd3, 10'd512,  4'd2, 1'b0},
    {3'd0, 3'd4, 10'd0,    4'd5, 1'b0},
    {3'd1, 3'd5, 10'd900,  4'd3, 1'b1},
    {3'd0, 3'd7, 10'd10,   4'd1, 1'b0},
    {3'd7, 3'd0, 10'd777,  4'd0, 1'b0},
    {3'd4, 3'd6, 10'd1000, 4'd0, 1'b1}
  };

  logic       clk = 1'b0, rst_n = 1'b0, start = 1'b0, cmp;
  logic [2:0] div_sel = '0, avg_sel = '0;
  logic [9:0] dac_code, result;
  logic       sample, busy, done;

  int errors = 0, checks = 0, idx = 0, idx0 = 0, base_r = 0, delta_r = 0;
  bit finished = 1'b0;
  int vin;

  always #(CLK_PERIOD / 2) clk = ~clk;

  // comparator model: input level rises by delta_r with each sampled conversion
  assign vin = base_r + delta_r * (idx - idx0);
  assign cmp = (int'(dac_code) <= vin);

  always @(negedge clk) if (sample) idx <= idx + 1;

  aux_sar_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .div_sel_i(div_sel),
    .avg_sel_i(avg_sel), .cmp_i(cmp), .dac_code_o(dac_code), .sample_o(sample),
    .result_o(result), .busy_o(busy), .done_o(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_result(input int a_sel, input int b, input int dl);
    int lg  = (a_sel > 5) ? 5 : a_sel;
    int sum = 0;
    for (int j = 1; j <= (1 << lg); j++) sum += b + dl * j;
    return sum >> lg;
  endfunction

  task automatic run(input logic [20:0] v);
    logic [2:0] d = v[20:18];
    logic [2:0] a = v[17:15];
    int b  = int'(v[14:5]);
    int dl = int'(v[4:1]);
    bit inj = v[0];
    int cnt = 1 << ((a > 3'd5) ? 5 : int'(a));
    int t   = 12 * cnt * (1 << d);
    int ev  = exp_result(int'(a), b, dl);
    @(negedge clk);
    start = 1'b1; div_sel = d; avg_sel = a;
    base_r = b; delta_r = dl; idx0 = idx;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    for (int k = 1; k < t; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (inj && k == 3) begin
        start = 1'b1; div_sel = ~d; avg_sel = ~a;  // R8 R9 disturbance
      end else begin
        start = 1'b0;
      end
    end
    chk(busy == 1'b1 && done == 1'b0, "R6 busy held to last cycle", int'({busy, done}), 2);
    @(posedge clk);
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b1, "R6 done at busy fall (R4 divisor)", int'({busy, done}), 1);
    chk(int'(result) == ev, inj ? "R8 R9 R5 result" : "R3 R5 result", int'(result), ev);
    chk((idx - idx0) == cnt, "R7 sample count", idx - idx0, cnt);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R1 flags in reset", int'({busy, done}), 0);
    chk(result == '0 && dac_code == '0, "R1 data in reset", int'(result), 0);
    rst_n = 1'b1;
    for (int i = 0; i < NVEC; i++) run(VEC[i]);
    // R10: result held, done low, after completion
    repeat (20) @(negedge clk);
    chk(result == 10'd1000, "R10 result held", int'(result), 1000);
    chk(done == 1'b0 && busy == 1'b0, "R10 idle after done", int'({busy, done}), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule